// File: doc/BRIEF.md
# Three-Channel Inverter PWM with Dead Time

This block drives the six gate signals of a three-phase inverter. Each of its three channels has a period counter, a period limit and a duty match value, and it produces a complementary A/B pin pair. A programmable dead-time counter holds back every switch-on so that the high-side and low-side switches of one leg are never on together. Each channel can count up and wrap (edge-aligned) or count up and down (centre-aligned). Instead of counting clock cycles it can also count rising edges on its own external input, and it keeps a captured counter value for each such edge.

Two whole-block modes serve brushless motor drive. In pattern steering mode, the active-state signal of channel 0's A pin is sent to any chosen subset of the six pins, so six-step commutation becomes a single mask write. In shared-counter mode, channels 1 and 2 compare their match values against channel 0's counter, which gives three phase-locked duty cycles. An active-low abort input forces every pin to its passive level at once. Configuration goes through a write-only register port.

Top module: `mpwm_tri`

## Requirements
- R1: Register map, written when wr_en is high at a rising clock edge. For channel c (0..2) the base address is 4c. Offset 0 holds the period limit L, offset 1 the duty match M, and offset 2 the dead time D in bits [9:0]. Offset 3 is control: bit0 run, bit1 centre-aligned, bit2 count external edges, bit3 polarity. Address 12 is the mode: bit0 pattern steering, bit1 shared counter. Address 13 is the 6-bit steering mask.
- R2: After reset every pin is low and every captured value is zero.
- R3: Edge-aligned mode: the counter runs 0..L and wraps, so the period is L+1 cycles. The A pin is active while counter ≥ M and B is active otherwise. With D=0, A is active for L−M+1 cycles per period. M=0 keeps A always active and M>L keeps it never active.
- R4: Centre-aligned mode: the counter climbs to L and falls back to 0, so the period is 2L cycles. With D=0, A is active for 2(L−M)+1 cycles per period and B for 2M−1.
- R5: A switch-on (passive to active) comes D cycles after the request. A switch-off is immediate. A and B of one channel are never active together. In edge-aligned mode A is then active for L−M+1−D cycles per period and B for M−D.
- R6: With the polarity bit set, the passive level of both pins of that channel is high and the active level is low.
- R7: Limit and match writes made while a channel runs take effect only at the period boundary: the wrap in edge-aligned mode, or the return to 0 in centre-aligned mode. While a channel is stopped they take effect at once.
- R8: In external-edge mode, the counter advances once per rising edge of the channel's mci bit, wraps at L, and holds between edges. On every rising edge of mci the channel's capture register takes the counter value from before that edge's increment.
- R9: Pattern steering: mask bit 2c gates channel c's A pin and bit 2c+1 gates its B pin. A gated-on pin carries channel 0's A active state, with channel c's own polarity applied. A gated-off pin stays passive.
- R10: Shared-counter mode: channels 1 and 2 compare their own match against channel 0's counter. They follow channel 0's run bit and period boundary, and their own limits are ignored.
- R11: While abort_n is low, all six pins sit at their passive levels from the first clock edge on. Normal output returns after abort_n goes high.
- R12: A stopped channel keeps its counter at 0 and both of its pins passive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| mci | input | 3 | Per-channel external event / capture input |
| abort_n | input | 1 | Active-low abort to passive state |
| pwm_a | output | 3 | A pin per channel (registered) |
| pwm_b | output | 3 | B pin per channel (registered) |
| cap_o | output | 96 | Captured counter value, channel c in bits [32c+31:32c] |

## Verification
An internal counter that runs past its limit or turns around in the wrong place changes the number of active cycles within the first period, so the bench counts active cycles per pin over whole periods. A shadow register that loads early shows within a few cycles: a duty cut in mid-period ends the active phase early. A lost dead-time count or bad steering shows either as an A/B overlap or as a wrong active-cycle count on the first measured window. Captured values expose the event counter directly, one edge after it moves.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  localparam int REGS_PER_CH = 4;
  localparam int OFS_LIM     = 0;
  localparam int OFS_MAT     = 1;
  localparam int OFS_DT      = 2;
  localparam int OFS_CTL     = 3;

  typedef struct packed {
    logic pol;
    logic evt;
    logic centre;
    logic run;
  } ch_ctl_t;

  typedef struct packed {
    logic ac;
    logic dc;
  } mode_t;

endpackage

// File: rtl/mpwm_timer.sv
module mpwm_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          centre,
  input  logic          evt_mode,
  input  logic          mci_rise,
  input  logic [CW-1:0] lim_wr,
  input  logic [CW-1:0] mat_wr,
  input  logic          use_ext,
  input  logic [CW-1:0] ext_cnt,
  input  logic          ext_ld,
  output logic [CW-1:0] cnt_o,
  output logic          ld_o,
  output logic          act_o,
  output logic [CW-1:0] cap_o
);

  logic [CW-1:0] cnt, lim_act, mat_act, cap;
  logic          down;
  logic          tick, pe, mat_ld;

  assign tick = evt_mode ? mci_rise : 1'b1;

  always_comb begin
    if (!centre) pe = tick && (cnt >= lim_act);
    else         pe = tick && (cnt == '0) && (down || (lim_act == '0));
  end

  assign ld_o   = !run || pe;
  assign mat_ld = use_ext ? ext_ld : ld_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      down    <= 1'b0;
      lim_act <= '0;
      mat_act <= '0;
      cap     <= '0;
    end else begin
      if (mci_rise) cap <= cnt;
      if (ld_o)     lim_act <= lim_wr;
      if (mat_ld)   mat_act <= mat_wr;
      if (!run) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (tick) begin
        if (!centre) begin
          down <= 1'b0;
          cnt  <= pe ? '0 : cnt + 1'b1;
        end else if (!down) begin
          if (cnt >= lim_act) begin
            if (cnt != '0) begin
              down <= 1'b1;
              cnt  <= cnt - 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            down <= 1'b0;
            cnt  <= (lim_wr != '0) ? CW'(1) : '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  assign cnt_o = cnt;
  assign cap_o = cap;
  assign act_o = (use_ext ? ext_cnt : cnt) >= mat_act;

  // R3 / R4: the counter never leaves 0..limit
  a_r3_cnt_within_limit: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim_act);

  // R7: a running channel takes a new limit only at its period boundary
  a_r7_shadow_at_boundary: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$stable(lim_act)) |-> (cnt <= CW'(1)));

  // R8: without an input edge the event counter holds
  a_r8_hold_without_event: assert property (@(posedge clk) disable iff (rst)
    (run && evt_mode && !mci_rise) |=> $stable(cnt));

endmodule

// File: rtl/mpwm_deadband.sv
module mpwm_deadband #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          act,
  input  logic [DW-1:0] dt,
  output logic          a_on,
  output logic          b_on
);

  logic          prev, live;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      prev <= 1'b0;
      live <= 1'b0;
      cnt  <= '0;
    end else begin
      live <= 1'b1;
      if (!live || (act != prev)) begin
        prev <= act;
        cnt  <= '0;
      end else if (cnt < dt) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign a_on = live &&  prev && (cnt >= dt);
  assign b_on = live && !prev && (cnt >= dt);

  // R5: with a non-zero dead time, a switch-on never directly follows the other side
  a_r5_gap_before_a: assert property (@(posedge clk) disable iff (rst)
    ((dt != '0) && $rose(a_on)) |-> !$past(b_on));
  a_r5_gap_before_b: assert property (@(posedge clk) disable iff (rst)
    ((dt != '0) && $rose(b_on)) |-> !$past(a_on));

  // R12: a disabled channel requests nothing
  a_r12_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!a_on && !b_on));

endmodule

// File: rtl/mpwm_tri.sv
module mpwm_tri
  import mpwm_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 32,
  parameter int DW  = 10,
  parameter int AW  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_data,
  input  logic [NCH-1:0]   mci,
  input  logic             abort_n,
  output logic [NCH-1:0]   pwm_a,
  output logic [NCH-1:0]   pwm_b,
  output logic [NCH*CW-1:0] cap_o
);

  localparam int ADDR_MODE = NCH * REGS_PER_CH;
  localparam int ADDR_PAT  = ADDR_MODE + 1;
  localparam int PW        = 2 * NCH;

  logic [CW-1:0] lim_r [NCH];
  logic [CW-1:0] mat_r [NCH];
  logic [DW-1:0] dt_r  [NCH];
  ch_ctl_t       ctl_r [NCH];
  mode_t         mode_r;
  logic [PW-1:0] pat_r;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        lim_r[i] <= '0;
        mat_r[i] <= '0;
        dt_r[i]  <= '0;
        ctl_r[i] <= '0;
      end
      mode_r <= '0;
      pat_r  <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == AW'(i*REGS_PER_CH + OFS_LIM)) lim_r[i] <= wr_data;
        if (wr_addr == AW'(i*REGS_PER_CH + OFS_MAT)) mat_r[i] <= wr_data;
        if (wr_addr == AW'(i*REGS_PER_CH + OFS_DT))  dt_r[i]  <= wr_data[DW-1:0];
        if (wr_addr == AW'(i*REGS_PER_CH + OFS_CTL)) ctl_r[i] <= ch_ctl_t'(wr_data[3:0]);
      end
      if (wr_addr == AW'(ADDR_MODE)) mode_r <= mode_t'(wr_data[1:0]);
      if (wr_addr == AW'(ADDR_PAT))  pat_r  <= wr_data[PW-1:0];
    end
  end

  logic [CW-1:0]  cnt_v [NCH];
  logic [NCH-1:0] ld_v, act_v, a_on, b_on, en_v, rise_v, pol_v, use_ext_v;
  logic [NCH-1:0] a_sel, b_sel, mask_a, mask_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [2:0] sh;

    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[1:0], mci[c]};
    end
    assign rise_v[c]    = sh[1] & ~sh[2];
    assign use_ext_v[c] = mode_r.ac && (c != 0);
    assign en_v[c]      = use_ext_v[c] ? ctl_r[0].run : ctl_r[c].run;
    assign pol_v[c]     = ctl_r[c].pol;
    assign mask_a[c]    = pat_r[2*c];
    assign mask_b[c]    = pat_r[2*c+1];

    mpwm_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .run      (ctl_r[c].run),
      .centre   (ctl_r[c].centre),
      .evt_mode (ctl_r[c].evt),
      .mci_rise (rise_v[c]),
      .lim_wr   (lim_r[c]),
      .mat_wr   (mat_r[c]),
      .use_ext  (use_ext_v[c]),
      .ext_cnt  (cnt_v[0]),
      .ext_ld   (ld_v[0]),
      .cnt_o    (cnt_v[c]),
      .ld_o     (ld_v[c]),
      .act_o    (act_v[c]),
      .cap_o    (cap_o[c*CW +: CW])
    );

    mpwm_deadband #(.DW(DW)) u_dead (
      .clk  (clk),
      .rst  (rst),
      .en   (en_v[c]),
      .act  (act_v[c]),
      .dt   (dt_r[c]),
      .a_on (a_on[c]),
      .b_on (b_on[c])
    );

    assign a_sel[c] = mode_r.dc ? (mask_a[c] & a_on[0]) : a_on[c];
    assign b_sel[c] = mode_r.dc ? (mask_b[c] & a_on[0]) : b_on[c];
  end

  // registered pin stage with abort override
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_a <= '0;
      pwm_b <= '0;
    end else if (!abort_n) begin
      pwm_a <= pol_v;
      pwm_b <= pol_v;
    end else begin
      pwm_a <= a_sel ^ pol_v;
      pwm_b <= b_sel ^ pol_v;
    end
  end

  // R11: abort drives every pin to its passive level on the next edge
  a_r11_abort_passive: assert property (@(posedge clk) disable iff (rst)
    !$past(abort_n) |-> ((pwm_a == $past(pol_v)) && (pwm_b == $past(pol_v))));

  // R9: pins outside the steering mask stay passive
  a_r9_unmasked_passive: assert property (@(posedge clk) disable iff (rst)
    $past(mode_r.dc && abort_n) |->
      ((((pwm_a ^ $past(pol_v)) & ~$past(mask_a)) == '0) &&
       (((pwm_b ^ $past(pol_v)) & ~$past(mask_b)) == '0)));

endmodule

// File: tb/tb_mpwm_tri.sv
module tb_mpwm_tri;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  mci = '0;
  logic        abort_n = 1'b1;
  logic [2:0]  pwm_a, pwm_b;
  logic [95:0] cap_o;

  int checks = 0;
  int fails  = 0;
  int ca [3];
  int cb [3];
  int both_hi;

  always #10 clk = ~clk;

  mpwm_tri dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mci(mci), .abort_n(abort_n), .pwm_a(pwm_a), .pwm_b(pwm_b), .cap_o(cap_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; abort_n = 1'b1; mci = '0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setup_ch(input int c, input int l, input int m, input int d, input int ctl);
    wr(4*c + 0, l);
    wr(4*c + 1, m);
    wr(4*c + 2, d);
    wr(4*c + 3, ctl);
  endtask

  task automatic measure(input int n);
    for (int c = 0; c < 3; c++) begin ca[c] = 0; cb[c] = 0; end
    both_hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        ca[c] += int'(pwm_a[c]);
        cb[c] += int'(pwm_b[c]);
        if (pwm_a[c] && pwm_b[c]) both_hi++;
      end
    end
  endtask

  task automatic pulse_mci(input int c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mci[c] = 1'b1;
      repeat (3) @(negedge clk);
      mci[c] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset;
    @(negedge clk);
    chk("R2 pwm_a after reset", int'(pwm_a), 0);
    chk("R2 pwm_b after reset", int'(pwm_b), 0);
    chk("R2 capture after reset", int'(cap_o[31:0]), 0);
  endtask

  task automatic t_edge;
    do_reset;
    setup_ch(0, 9, 4, 0, 1);
    repeat (30) @(negedge clk);
    measure(50);
    chk("R1 R3 edge A active", ca[0], 30);
    chk("R3 edge B active", cb[0], 20);
    chk("R12 stopped ch1 A", ca[1], 0);
    chk("R12 stopped ch1 B", cb[1], 0);
  endtask

  task automatic t_edge_bounds;
    do_reset;
    setup_ch(0, 9, 0, 0, 1);
    repeat (30) @(negedge clk);
    measure(50);
    chk("R3 match 0 A always", ca[0], 50);
    chk("R3 match 0 B never", cb[0], 0);
    do_reset;
    setup_ch(0, 9, 12, 0, 1);
    repeat (30) @(negedge clk);
    measure(50);
    chk("R3 match above limit A never", ca[0], 0);
    chk("R3 match above limit B always", cb[0], 50);
  endtask

  task automatic t_centre;
    do_reset;
    setup_ch(0, 8, 3, 0, 3);
    repeat (40) @(negedge clk);
    measure(64);
    chk("R4 centre A active", ca[0], 44);
    chk("R4 centre B active", cb[0], 20);
  endtask

  task automatic t_dead;
    do_reset;
    setup_ch(0, 9, 4, 2, 1);
    repeat (30) @(negedge clk);
    measure(50);
    chk("R5 dead time A active", ca[0], 20);
    chk("R5 dead time B active", cb[0], 10);
    chk("R5 no overlap", both_hi, 0);
  endtask

  task automatic t_pol;
    do_reset;
    setup_ch(0, 9, 4, 0, 9);
    repeat (30) @(negedge clk);
    measure(50);
    chk("R6 inverted A pin high", ca[0], 20);
    chk("R6 inverted B pin high", cb[0], 30);
  endtask

  task automatic t_shadow;
    int hi;
    do_reset;
    setup_ch(0, 19, 10, 0, 1);
    while (!pwm_a[0]) @(negedge clk);
    wr(1, 18);
    hi = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      hi += int'(pwm_a[0]);
    end
    chk("R7 match held until period end", hi, 4);
    repeat (45) @(negedge clk);
    measure(60);
    chk("R7 new match after boundary A", ca[0], 6);
    chk("R7 new match after boundary B", cb[0], 54);
  endtask

  task automatic t_event;
    do_reset;
    setup_ch(0, 2, 1, 0, 5);
    pulse_mci(0, 3);
    chk("R8 capture after three edges", int'(cap_o[31:0]), 2);
    pulse_mci(0, 1);
    chk("R8 capture after wrap at limit", int'(cap_o[31:0]), 0);
    repeat (20) @(negedge clk);
    pulse_mci(0, 1);
    chk("R8 counter held between edges", int'(cap_o[31:0]), 1);
  endtask

  task automatic t_dc;
    do_reset;
    wr(12, 1);
    wr(13, 6'b001001);
    setup_ch(0, 9, 4, 0, 1);
    repeat (30) @(negedge clk);
    measure(50);
    chk("R9 steered ch0 A", ca[0], 30);
    chk("R9 masked ch0 B", cb[0], 0);
    chk("R9 masked ch1 A", ca[1], 0);
    chk("R9 steered ch1 B", cb[1], 30);
    chk("R9 masked ch2", ca[2] + cb[2], 0);
  endtask

  task automatic t_ac;
    do_reset;
    wr(12, 2);
    setup_ch(1, 50, 2, 0, 0);
    setup_ch(2, 50, 7, 0, 0);
    setup_ch(0, 9, 4, 0, 1);
    repeat (30) @(negedge clk);
    measure(50);
    chk("R10 shared ch1 A", ca[1], 40);
    chk("R10 shared ch1 B", cb[1], 10);
    chk("R10 shared ch2 A", ca[2], 15);
    chk("R10 shared ch2 B", cb[2], 35);
  endtask

  task automatic t_abort;
    do_reset;
    setup_ch(2, 9, 4, 0, 8);
    setup_ch(0, 9, 4, 0, 1);
    repeat (30) @(negedge clk);
    abort_n = 1'b0;
    @(negedge clk);
    measure(10);
    chk("R11 abort ch0 A", ca[0], 0);
    chk("R11 abort ch0 B", cb[0], 0);
    chk("R11 abort ch2 passive high", ca[2] + cb[2], 20);
    abort_n = 1'b1;
    repeat (30) @(negedge clk);
    measure(50);
    chk("R11 resume after release", ca[0], 30);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_edge;
    t_edge_bounds;
    t_centre;
    t_dead;
    t_pol;
    t_shadow;
    t_event;
    t_dc;
    t_ac;
    t_abort;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule